// File: doc/BRIEF.md
# Nibble-Bus DAC Output Word Loader

This block hands a 12-bit output code to one channel of a dual 12-bit DAC whose data bus is only four bits wide. A single-cycle start pulse captures the code. The block then makes four addressed writes over the narrow bus. The first three fill the channel's low, mid and high nibble input registers. The fourth targets the channel's transfer address, which moves the assembled word into the DAC output register. Every write pulses the active-low write strobe while the address and data stay steady. Chip select frames the four writes. A one-cycle done pulse closes the sequence.

Bus timing is counted in clock cycles. Each write spends one setup cycle with the strobe high, `WR_LOW_CYC` cycles with the strobe low, and one hold cycle with the strobe high again. Throughout the sequence the update line stays high and the clear line stays inactive. The code arrives as two bytes. The upper byte carries the top nibble in its low half. The lower byte carries the mid nibble in its upper half and the low nibble in its lower half.

Top module: `dac_nib_loader`

## Requirements
- R1: During and right after reset, dac_cs_n = 1, dac_wr_n = 1, dac_upd = 1, dac_clr = 0 and done = 0.
- R2: The clock edge that accepts start drives dac_cs_n low. dac_cs_n stays low for 4*(WR_LOW_CYC+2) cycles, covering the last write's hold cycle, and then returns high.
- R3: dac_upd stays 1 and dac_clr stays 0 at all times.
- R4: The four writes occur in a fixed order on dac_addr: address 4 (low nibble), then 5 (mid nibble), then 6 (high nibble), then 7 (load DAC register, dac_data = 0).
- R5: The code is taken as {code_hi[3:0], code_lo[7:4], code_lo[3:0]} for the high, mid and low nibbles. code_hi[7:4] has no effect.
- R6: Each write holds dac_addr and dac_data for one cycle before dac_wr_n falls, for the whole low phase, and for the cycle in which dac_wr_n rises.
- R7: dac_wr_n stays low for exactly WR_LOW_CYC consecutive cycles per write, and only while dac_cs_n is low. WR_LOW_CYC must be at least 2.
- R8: A start that arrives while a sequence is running, including its cs-high and done cycles, is ignored. It causes no extra write, and the bus stays idle afterwards.
- R9: done is high for exactly one cycle. That cycle follows the first cycle with dac_cs_n high again, so done rises 4*WR_LOW_CYC+9 edges after the edge that accepted start.
- R10: The code is captured at the edge that accepts start. Later changes on code_hi and code_lo do not alter the written nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to load a new code (accepted only when idle) |
| code_hi | input | 8 | Upper code byte; bits 3:0 are the top nibble |
| code_lo | input | 8 | Lower code byte; mid nibble in 7:4, low nibble in 3:0 |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_upd | output | 1 | Update line, held high |
| dac_clr | output | 1 | Clear line, held inactive (low) |
| dac_addr | output | 3 | DAC register address |
| dac_data | output | 4 | DAC nibble data bus |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is registered, so the bench counts cycles k from the edge that accepts start. At k the strobe is due low when (k mod (WR_LOW_CYC+2)) lies in 1..WR_LOW_CYC, and the address and nibble belong to write k div (WR_LOW_CYC+2). Chip select is due high at k = 4*(WR_LOW_CYC+2) and done at the cycle after that. The bench rebuilds this waveform from a function of k and compares all pins on the falling edge of every cycle. Between samples it scrambles the code inputs and fires stray start pulses, which tests capture and the rejection of a start while the block is busy.

// File: rtl/dnl_pkg.sv
package dnl_pkg;

  localparam int unsigned NIB_W   = 4;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned WORD_W  = 3 * NIB_W;
  localparam int unsigned N_SLOTS = 4;
  localparam int unsigned SLOT_W  = $clog2(N_SLOTS);
  localparam logic [ADDR_W-1:0] CH_BASE_ADDR = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HOLD,
    ST_CSUP,
    ST_DONE
  } dnl_state_e;

  // Bus address used by write slot 0..3 (low, mid, high, transfer)
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] slot);
    return CH_BASE_ADDR + {{(ADDR_W-SLOT_W){1'b0}}, slot};
  endfunction

  // Nibble carried on the data bus during write slot 0..3
  function automatic logic [NIB_W-1:0] slot_data(input logic [WORD_W-1:0] word,
                                                 input logic [SLOT_W-1:0] slot);
    logic [NIB_W-1:0] nib;
    case (slot)
      2'd0:    nib = word[NIB_W-1:0];
      2'd1:    nib = word[2*NIB_W-1:NIB_W];
      2'd2:    nib = word[3*NIB_W-1:2*NIB_W];
      default: nib = '0;
    endcase
    return nib;
  endfunction

  // Assemble the code word from its two input bytes
  function automatic logic [WORD_W-1:0] pack_code(input logic [NIB_W-1:0] top_nib,
                                                  input logic [2*NIB_W-1:0] low_byte);
    return {top_nib, low_byte};
  endfunction

  function automatic logic in_frame(input dnl_state_e st);
    return (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HOLD);
  endfunction

endpackage

// File: rtl/dnl_word_cap.sv
module dnl_word_cap
  import dnl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic [NIB_W-1:0]    top_nib,
  input  logic [2*NIB_W-1:0]  low_byte,
  output logic [WORD_W-1:0]   word_nxt
);

  logic [WORD_W-1:0] word_q;

  assign word_nxt = cap ? pack_code(top_nib, low_byte) : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_nxt;
  end

endmodule

// File: rtl/dnl_seq.sv
module dnl_seq
  import dnl_pkg::*;
#(
  parameter int unsigned WR_LOW_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output dnl_state_e        st_nxt,
  output logic [SLOT_W-1:0] slot_nxt
);

  localparam int unsigned CNT_W = $clog2(WR_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_LOW_CYC);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);

  dnl_state_e        st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;

  assign accept = (st_q == ST_IDLE) && start;

  always_comb begin
    st_nxt   = st_q;
    slot_nxt = slot_q;
    cnt_nxt  = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_nxt   = ST_SETUP;
          slot_nxt = '0;
        end
      end
      ST_SETUP: begin
        st_nxt  = ST_LOW;
        cnt_nxt = CNT_W'(1);
      end
      ST_LOW: begin
        if (cnt_q == CNT_LAST) st_nxt = ST_HOLD;
        else                   cnt_nxt = cnt_q + CNT_W'(1);
      end
      ST_HOLD: begin
        if (slot_q == SLOT_LAST) begin
          st_nxt = ST_CSUP;
        end else begin
          st_nxt   = ST_SETUP;
          slot_nxt = slot_q + SLOT_W'(1);
        end
      end
      ST_CSUP: st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_nxt;
      slot_q <= slot_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/dnl_pins.sv
module dnl_pins
  import dnl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dnl_state_e        st_nxt,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic [WORD_W-1:0] word_nxt,
  output logic              cs_n,
  output logic              wr_n,
  output logic              upd,
  output logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic [NIB_W-1:0]  data,
  output logic              done
);

  logic frame_nxt;
  assign frame_nxt = in_frame(st_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      wr_n <= 1'b1;
      upd  <= 1'b1;
      clr  <= 1'b0;
      addr <= '0;
      data <= '0;
      done <= 1'b0;
    end else begin
      cs_n <= !frame_nxt;
      wr_n <= (st_nxt != ST_LOW);
      upd  <= 1'b1;
      clr  <= 1'b0;
      addr <= frame_nxt ? slot_addr(slot_nxt) : '0;
      data <= frame_nxt ? slot_data(word_nxt, slot_nxt) : '0;
      done <= (st_nxt == ST_DONE);
    end
  end

endmodule

// File: rtl/dac_nib_loader.sv
module dac_nib_loader
  import dnl_pkg::*;
#(
  parameter int unsigned WR_LOW_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  code_hi,
  input  logic [7:0]  code_lo,
  output logic        dac_cs_n,
  output logic        dac_wr_n,
  output logic        dac_upd,
  output logic        dac_clr,
  output logic [2:0]  dac_addr,
  output logic [3:0]  dac_data,
  output logic        done
);

  if (WR_LOW_CYC < 2) begin : g_bad_width
    $error("WR_LOW_CYC must be at least 2");
  end

  // Named internal events, observed by the bound checker
  logic              accept_evt;
  dnl_state_e        st_nxt;
  logic [SLOT_W-1:0] slot_nxt;
  logic [WORD_W-1:0] word_nxt;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^code_hi[7:4];

  dnl_seq #(.WR_LOW_CYC(WR_LOW_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept_evt),
    .st_nxt   (st_nxt),
    .slot_nxt (slot_nxt)
  );

  dnl_word_cap u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (accept_evt),
    .top_nib  (code_hi[3:0]),
    .low_byte (code_lo),
    .word_nxt (word_nxt)
  );

  dnl_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_nxt   (st_nxt),
    .slot_nxt (slot_nxt),
    .word_nxt (word_nxt),
    .cs_n     (dac_cs_n),
    .wr_n     (dac_wr_n),
    .upd      (dac_upd),
    .clr      (dac_clr),
    .addr     (dac_addr),
    .data     (dac_data),
    .done     (done)
  );

endmodule

// File: rtl/dac_nib_loader_chk.sv
module dac_nib_loader_chk #(
  parameter int unsigned WR_LOW_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept_evt,
  input logic       dac_cs_n,
  input logic       dac_wr_n,
  input logic       dac_upd,
  input logic       dac_clr,
  input logic [2:0] dac_addr,
  input logic [3:0] dac_data,
  input logic       done
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= 0;
    else if (!dac_wr_n) low_run <= low_run + 1;
    else               low_run <= 0;
  end

  p_cs_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !dac_cs_n);

  p_lines_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd && !dac_clr);

  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_hold_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (low_run == WR_LOW_CYC));

  p_wr_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !dac_cs_n);

  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !accept_evt);

  p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (dac_cs_n && $past(dac_cs_n)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dac_nib_loader dac_nib_loader_chk #(.WR_LOW_CYC(WR_LOW_CYC)) u_chk (.*);

// File: tb/dac_nib_loader_tb_top.sv
module dac_nib_loader_tb_top;

  localparam int W   = 3;
  localparam int PER = W + 2;
  localparam int SEQ = 4 * PER;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] code_hi = '0;
  logic [7:0] code_lo = '0;
  logic       dac_cs_n, dac_wr_n, dac_upd, dac_clr, done;
  logic [2:0] dac_addr;
  logic [3:0] dac_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dac_nib_loader #(.WR_LOW_CYC(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code_hi(code_hi), .code_lo(code_lo),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n), .dac_upd(dac_upd),
    .dac_clr(dac_clr), .dac_addr(dac_addr), .dac_data(dac_data),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected nibble per write index, taken straight from the byte layout (R5)
  function automatic int exp_nib(input logic [7:0] hi, input logic [7:0] lo, input int idx);
    case (idx)
      0: return int'(lo & 8'h0F);
      1: return int'(lo >> 4);
      2: return int'(hi & 8'h0F);
      default: return 0;
    endcase
  endfunction

  // One transfer; inj_k >= 0 drives a stray start after sample k
  task automatic run_xfer(input logic [7:0] hi, input logic [7:0] lo, input int inj_k);
    @(negedge clk);
    start = 1'b1; code_hi = hi; code_lo = lo;
    for (int k = 0; k <= SEQ + 2; k++) begin
      @(negedge clk);
      if (k < SEQ) begin
        int idx = k / PER;
        int ph  = k % PER;
        chk("R2 cs_n", int'(dac_cs_n), 0);
        chk("R7 R6 wr_n", int'(dac_wr_n), (ph >= 1 && ph <= W) ? 0 : 1);
        chk("R4 addr", int'(dac_addr), 4 + idx);
        chk("R5 R10 data", int'(dac_data), exp_nib(hi, lo, idx));
        chk("R9 done low", int'(done), 0);
      end else begin
        chk("R2 cs_n high", int'(dac_cs_n), 1);
        chk("R7 wr_n high", int'(dac_wr_n), 1);
        chk("R9 done", int'(done), (k == SEQ + 1) ? 1 : 0);
      end
      chk("R3 upd", int'(dac_upd), 1);
      chk("R3 clr", int'(dac_clr), 0);
      code_hi = 8'($urandom);
      code_lo = 8'($urandom);
      start = (k == inj_k) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk("R8 stays idle cs_n", int'(dac_cs_n), 1);
      chk("R8 stays idle wr_n", int'(dac_wr_n), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk("R1 cs_n", int'(dac_cs_n), 1);
    chk("R1 wr_n", int'(dac_wr_n), 1);
    chk("R1 upd", int'(dac_upd), 1);
    chk("R1 clr", int'(dac_clr), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cs_n after release", int'(dac_cs_n), 1);
    chk("R1 done after release", int'(done), 0);

    run_xfer(8'h0F, 8'hFF, -1);
    run_xfer(8'h00, 8'h00, -1);
    run_xfer(8'hA5, 8'h3C, 3);        // R5 junk upper bits, R8 start in setup/low
    run_xfer(8'hF7, 8'h21, SEQ);      // R8 start in cs-high cycle
    run_xfer(8'h09, 8'h6E, SEQ + 1);  // R8 start in done cycle
    run_xfer(8'h03, 8'hB4, SEQ - 1);  // R8 start in last hold

    for (int t = 0; t < 30; t++) begin
      logic [7:0] h = 8'($urandom);
      logic [7:0] l = 8'($urandom);
      int inj = ($urandom % 2 == 0) ? -1 : int'($urandom % (SEQ + 2));
      run_xfer(h, l, inj);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule